// File: doc/BRIEF.md
# Base-Limit Relocation Protection Unit

This unit sits between a processor and memory and handles every address the processor issues. Each request carries a logical address and a mode bit. A user-mode address is checked against a limit register. If it is in range, the unit relocates it by adding a base register, and the result is sent on to memory. If the address is out of range, or the sum does not fit the physical address width, the unit returns a fault code instead of an address. Kernel-mode requests are not translated: the logical address is passed through unchanged as the physical address.

The base register holds the lowest physical address the running process owns. The limit register holds the size of that process's logical space. A separate register-write port loads both registers together, typically when the running process changes. Only a kernel-mode write is accepted. A user-mode write is refused, leaves both registers as they were, and raises a one-cycle privilege-violation flag.

Requests use a valid/ready channel, and responses come back one cycle after acceptance on a second valid/ready channel. The unit holds one response at a time, so it accepts a new request whenever its output is empty or is being taken in the same cycle.

Top module: `reloc_guard`

## Requirements
- R1: After reset, rsp_valid and cfg_denied are 0, req_ready is 1, base is 0 and limit is 0. Because of that, a user request at logical address 0 faults with code 01.
- R2: A user request (req_user=1) whose address is strictly less than the limit, and where base plus address fits in PA_W bits, returns rsp_addr = base + address with rsp_fault = 00.
- R3: A user request whose address is greater than or equal to the limit returns rsp_fault = 01 and rsp_addr = 0. This code takes priority over the overflow code.
- R4: An in-range user request where base plus address is 2^PA_W or more returns rsp_fault = 10 and rsp_addr = 0.
- R5: A kernel request (req_user=0) returns its logical address, zero-extended, as rsp_addr, with rsp_fault = 00, whatever the base and limit hold.
- R6: A write with cfg_we=1 and cfg_user=0 loads cfg_base and cfg_limit into base and limit together at that clock edge.
- R7: A write with cfg_we=1 and cfg_user=1 leaves base and limit unchanged. It drives cfg_denied high for exactly the following cycle. cfg_denied is low in every other cycle.
- R8: A request accepted in the same cycle as a register write is handled with the old base and limit. Requests accepted in later cycles use the new values.
- R9: A request is accepted when req_valid and req_ready are both 1, where req_ready = !rsp_valid || rsp_ready. Its response appears on the next cycle. While rsp_valid=1 and rsp_ready=0, the response holds stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | LA_W | Logical address |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | PA_W | Physical address (0 on a fault) |
| rsp_fault | output | 2 | 00 ok, 01 out of bounds, 10 overflow |
| cfg_we | input | 1 | Register write strobe |
| cfg_user | input | 1 | Mode of the writer, 1 = user |
| cfg_base | input | PA_W | New base value |
| cfg_limit | input | LA_W+1 | New limit value |
| cfg_denied | output | 1 | Pulse after a refused user write |

## Verification
User addresses are tried just below, at and above the limit. This separates a strict compare from an inclusive one. Sums are placed at exactly the top physical address and one past it, which pins down where the overflow fault begins. One address is both out of bounds and overflowing, which shows which fault wins. Kernel addresses under a nonzero base show that no translation is applied. A write is made in the same cycle as a request, and a user write is followed by a request, which shows when an update takes effect and that a refused one changes nothing. Stalled responses and a random mix of all of these are compared against the bench model on every cycle.

// File: rtl/reloc_guard.sv
module reloc_guard #(
  parameter int LA_W  = 12,
  parameter int PA_W  = 16,
  parameter int LIM_W = LA_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LA_W-1:0]  req_addr,
  input  logic             req_user,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_addr,
  output logic [1:0]       rsp_fault,
  input  logic             cfg_we,
  input  logic             cfg_user,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [LIM_W-1:0] cfg_limit,
  output logic             cfg_denied
);
  localparam logic [1:0] F_OK    = 2'b00;
  localparam logic [1:0] F_BOUND = 2'b01;
  localparam logic [1:0] F_OVF   = 2'b10;

  logic [PA_W-1:0]  base_q;
  logic [LIM_W-1:0] limit_q;
  logic [PA_W:0]    sum;
  logic             in_bound;
  logic             accept;
  logic [PA_W-1:0]  nx_addr;
  logic [1:0]       nx_fault;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign sum       = {1'b0, base_q} + (PA_W+1)'(req_addr);
  assign in_bound  = LIM_W'(req_addr) < limit_q;

  always_comb begin
    nx_addr  = '0;
    nx_fault = F_OK;
    if (!req_user)
      nx_addr = PA_W'(req_addr);
    else if (!in_bound)
      nx_fault = F_BOUND;
    else if (sum[PA_W])
      nx_fault = F_OVF;
    else
      nx_addr = sum[PA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      limit_q    <= '0;
      cfg_denied <= 1'b0;
    end else begin
      cfg_denied <= cfg_we && cfg_user;
      if (cfg_we && !cfg_user) begin
        base_q  <= cfg_base;
        limit_q <= cfg_limit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= F_OK;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= nx_addr;
      rsp_fault <= nx_fault;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
  parameter int LA_W  = 12,
  parameter int PA_W  = 16,
  parameter int LIM_W = LA_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LA_W-1:0]  req_addr,
  input logic             req_user,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_addr,
  input logic [1:0]       rsp_fault,
  input logic             cfg_we,
  input logic             cfg_user,
  input logic             cfg_denied,
  input logic [LIM_W-1:0] limit_q
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault));

  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  p_fault_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'b00 |-> rsp_addr == '0);

  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_user && (LIM_W'(req_addr) >= limit_q)
    |=> rsp_valid && rsp_fault == 2'b01);

  p_kernel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_user
    |=> rsp_valid && rsp_fault == 2'b00 && rsp_addr == PA_W'($past(req_addr)));

  p_denied_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_user |=> cfg_denied);

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_user) |=> !cfg_denied);
endmodule

bind reloc_guard reloc_guard_chk #(.LA_W(LA_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_chk (.*);

// File: tb/tb_reloc_guard.sv
`timescale 1ns/1ps
module tb_reloc_guard;
  localparam int LA_W = 12, PA_W = 16, LIM_W = 13;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_user = 0, rsp_ready = 1;
  logic [LA_W-1:0] req_addr = 0;
  logic cfg_we = 0, cfg_user = 0;
  logic [PA_W-1:0] cfg_base = 0;
  logic [LIM_W-1:0] cfg_limit = 0;
  logic req_ready, rsp_valid, cfg_denied;
  logic [PA_W-1:0] rsp_addr;
  logic [1:0] rsp_fault;

  int checks = 0, fails = 0;
  int m_base = 0, m_limit = 0, m_addr = 0, m_fault = 0;
  bit m_valid = 0, m_denied = 0;

  always #2.5 clk = ~clk;

  reloc_guard dut (.*);

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " valid"}, rsp_valid, m_valid);
    if (m_valid) begin
      chk({tag, " addr"}, rsp_addr, m_addr);
      chk({tag, " fault"}, rsp_fault, m_fault);
    end
    chk({tag, " denied"}, cfg_denied, m_denied);
  endtask

  task automatic step(string tag, bit v, int a, bit u, bit rr,
                      bit we = 0, bit wu = 0, int b = 0, int l = 0);
    bit acc;
    int sum;
    int n_addr, n_fault, n_base, n_limit;
    bit n_valid;
    req_valid = v; req_addr = a[LA_W-1:0]; req_user = u; rsp_ready = rr;
    cfg_we = we; cfg_user = wu; cfg_base = b[PA_W-1:0]; cfg_limit = l[LIM_W-1:0];
    #1;
    chk({tag, " ready"}, req_ready, !m_valid || rr);
    acc = v && (!m_valid || rr);
    n_valid = acc ? 1 : (rr ? 0 : m_valid);
    n_addr = m_addr; n_fault = m_fault;
    if (acc) begin
      sum = m_base + a;
      if (!u) begin n_addr = a; n_fault = 0; end
      else if (a >= m_limit) begin n_addr = 0; n_fault = 1; end
      else if (sum >= (1 << PA_W)) begin n_addr = 0; n_fault = 2; end
      else begin n_addr = sum; n_fault = 0; end
    end
    n_base = m_base; n_limit = m_limit;
    if (we && !wu) begin n_base = b; n_limit = l; end
    @(posedge clk);
    @(negedge clk);
    m_valid = n_valid; m_addr = n_addr; m_fault = n_fault;
    m_base = n_base; m_limit = n_limit; m_denied = we && wu;
    req_valid = 0; cfg_we = 0;
    compare(tag);
  endtask

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1 reset");
    chk("R1 ready", req_ready, 1);
    step("R1 user at 0 vs zero limit", 1, 0, 1, 1);
    step("R5 kernel pass", 1, 'hABC, 0, 1);
    step("R6 kernel write", 0, 0, 0, 1, 1, 0, 'h1000, 'h100);
    step("R2 below limit", 1, 'h0FF, 1, 1);
    step("R3 at limit", 1, 'h100, 1, 1);
    step("R2 addr zero", 1, 0, 1, 1);
    step("R5 kernel under base", 1, 'h055, 0, 1);
    step("R7 user write", 0, 0, 0, 1, 1, 1, 'h2222, 'h800);
    step("R7 regs unchanged", 1, 'h0FF, 1, 1);
    step("R7 refused limit kept", 1, 'h200, 1, 1);
    step("R6 kernel write high base", 0, 0, 0, 1, 1, 0, 'hFF00, 'h1000);
    step("R4 top address", 1, 'h0FF, 1, 1);
    step("R4 overflow", 1, 'h100, 1, 1);
    step("R6 narrow limit", 0, 0, 0, 1, 1, 0, 'hFF00, 'h20);
    step("R3 priority over overflow", 1, 'h300, 1, 1);
    step("R8 write with request", 1, 'h010, 1, 1, 1, 0, 'h0100, 'h1000);
    step("R8 next uses new", 1, 'h010, 1, 1);
    step("R2 full limit", 1, 'hFFF, 1, 1);
    step("R9 stall accept", 1, 'h001, 1, 0);
    step("R9 stall hold", 1, 'h002, 1, 0);
    step("R9 stall hold2", 0, 0, 0, 0);
    step("R9 release", 1, 'h003, 0, 1);
    step("R9 drain", 0, 0, 0, 1);
    for (int i = 0; i < 300; i++) begin
      int r = $urandom;
      step("R9 mixed", r[0], $urandom_range(0, 4095), r[1], r[2] | r[3],
           r[4] & r[5], r[6], $urandom_range(0, 65535), $urandom_range(0, 4096));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule